// File: doc/BRIEF.md
# Sector Checksum Verifier

This block checks the integrity of one decoded disk sector as its bytes stream past. The stream holds 256 data bytes followed by four check bytes. Three 8-bit accumulators, called C, D and E, are seeded straight from the first three data bytes. Every later data byte then advances all three accumulators through a fixed shift-and-XOR recurrence, at a rate of one byte per accepted clock. This recurrence is not a standard CRC polynomial.

Once the data is complete, the next three bytes are compared against C, D and E in that order. The fourth byte must be the fixed marker 0x58. A one-cycle done pulse reports the result, together with a pass flag. The pass flag is set only when all four comparisons succeed.

A start pulse opens each sector. A start pulse during a sector that is in progress drops everything gathered so far and begins again. Upstream decoding and framing feed the block through a plain byte-valid strobe. Cycles where the strobe is low are stalls.

The control is a four-state machine:
- `ST_IDLE`: waits for a start pulse.
- `ST_SEED`: takes bytes 0 to 2.
- `ST_FOLD`: takes bytes 3 to 255.
- `ST_CHECK`: takes the four check bytes.

Its transitions are:
- T_START: any state to `ST_SEED` on `start_i`.
- T_SEEDED: `ST_SEED` to `ST_FOLD` on byte 2.
- T_FOLDED: `ST_FOLD` to `ST_CHECK` on byte 255.
- T_VERDICT: `ST_CHECK` to `ST_IDLE` on the fourth check byte.

Top module: `sector_check_engine`

## Requirements
- R1: A `start_i` pulse in any state clears the byte count and enters the seed phase. A byte presented in the same cycle as `start_i` is not accepted.
- R2: The first three accepted data bytes load C, D and E respectively, with no other transformation.
- R3: Each accepted data byte at positions 3 to 255 updates all three registers at once from their old values. The new C is the old D XOR the old C's bit 7 placed in bit 0. The new D is the old C shifted left one place (8 bits kept) XOR the old E. The new E is the old C XOR the byte.
- R4: The four bytes that follow the data are compared in order with C, D, E and 0x58. `pass_o` is 1 only if all four match. Any single mismatch gives 0.
- R5: `done_o` is high for exactly one cycle, the cycle right after the edge that accepts the fourth check byte. `pass_o` is valid in that cycle and holds its value until the next `start_i`.
- R6: Cycles with `byte_valid_i` low have no effect on the result. Idle gaps of any length anywhere in the stream give the same verdict.
- R7: Bytes presented while idle, with no start, are ignored. No `done_o` pulse follows them.
- R8: After reset, `done_o` and `pass_o` are 0 and the block is idle.
- R9: A sector cut short by a new `start_i` leaves no trace. The following complete sector gets the verdict it would get on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a new sector; has priority over a byte in the same cycle |
| byte_valid_i | input | 1 | Qualifies `byte_i` in this cycle |
| byte_i | input | 8 | Decoded sector or check byte |
| done_o | output | 1 | One-cycle pulse when the verdict is ready |
| pass_o | output | 1 | Verdict: 1 when all four check bytes match |

## Verification
The block registers its verdict once. `done_o` and `pass_o` therefore change at the same rising edge that takes in the fourth check byte, and they are due one half-cycle later. The bench drives every byte on a falling edge and samples on the next falling edge.

In the cycle after the fourth check byte, the bench expects `done_o` high with the reference verdict. One cycle later it expects `done_o` low again and `pass_o` unchanged. On every falling edge before the last byte it requires `done_o` to be low. It also walks idle bytes through cycle by cycle to confirm that no pulse appears.

// File: rtl/sce_pkg.sv
package sce_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEED  = 2'd1,
        ST_FOLD  = 2'd2,
        ST_CHECK = 2'd3
    } sce_state_t;

    localparam int SEED_COUNT  = 3;
    localparam int CHECK_COUNT = 4;

endpackage

// File: rtl/sce_byte_counter.sv
module sce_byte_counter #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          step_i,
    output logic [CW-1:0] cnt_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clear_i) begin
            cnt_o <= '0;
        end else if (step_i) begin
            cnt_o <= cnt_o + CW'(1);
        end
    end

    // R1: a start clears the position count
    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_o == '0));

    // R6: only accepted bytes advance the count
    assert_step_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !step_i) |=> $stable(cnt_o));

endmodule

// File: rtl/sce_fold_regs.sv
module sce_fold_regs
    import sce_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seed_en_i,
    input  logic [1:0] seed_sel_i,
    input  logic       fold_en_i,
    input  logic [7:0] byte_i,
    output logic [7:0] c_o,
    output logic [7:0] d_o,
    output logic [7:0] e_o
);

    logic [7:0] acc_q   [SEED_COUNT];
    logic [7:0] fold_nx [SEED_COUNT];

    // Simultaneous update: every next value taken from the old register set
    always_comb begin
        fold_nx[0] = acc_q[1] ^ {7'd0, acc_q[0][7]};
        fold_nx[1] = {acc_q[0][6:0], 1'b0} ^ acc_q[2];
        fold_nx[2] = acc_q[0] ^ byte_i;
    end

    for (genvar gi = 0; gi < SEED_COUNT; gi++) begin : g_acc
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q[gi] <= '0;
            end else if (seed_en_i && (seed_sel_i == 2'(gi))) begin
                acc_q[gi] <= byte_i;
            end else if (fold_en_i) begin
                acc_q[gi] <= fold_nx[gi];
            end
        end
    end

    assign c_o = acc_q[0];
    assign d_o = acc_q[1];
    assign e_o = acc_q[2];

    // R2: seeding copies the byte into the selected register
    assert_seed_c_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_en_i && seed_sel_i == 2'd0) |=> (c_o == $past(byte_i)));
    assert_seed_e_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_en_i && seed_sel_i == 2'd2) |=> (e_o == $past(byte_i) && $stable(c_o)));

    // R3: the recurrence between consecutive register sets
    assert_fold_e_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fold_en_i |=> (e_o == ($past(c_o) ^ $past(byte_i))));
    assert_fold_d_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fold_en_i |=> (d_o == ({$past(c_o[6:0]), 1'b0} ^ $past(e_o))));

    // R6: registers hold across stalls
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_en_i && !fold_en_i) |=> ($stable(c_o) && $stable(d_o) && $stable(e_o)));

endmodule

// File: rtl/sce_verdict.sv
module sce_verdict #(
    parameter logic [7:0] MARK = 8'h58
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       cmp_en_i,
    input  logic [1:0] cmp_sel_i,
    input  logic [7:0] byte_i,
    input  logic [7:0] c_i,
    input  logic [7:0] d_i,
    input  logic [7:0] e_i,
    output logic       ok_o,
    output logic       match_o
);

    logic [7:0] want;

    always_comb begin
        unique case (cmp_sel_i)
            2'd0:    want = c_i;
            2'd1:    want = d_i;
            2'd2:    want = e_i;
            default: want = MARK;
        endcase
    end

    assign match_o = (byte_i == want);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_o <= 1'b1;
        end else if (clear_i) begin
            ok_o <= 1'b1;
        end else if (cmp_en_i && !match_o) begin
            ok_o <= 1'b0;
        end
    end

    // R4: a mismatch is never forgotten before the next start
    assert_sticky_fail_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ok_o && !clear_i) |=> !ok_o);

endmodule

// File: rtl/sector_check_engine.sv
module sector_check_engine
    import sce_pkg::*;
#(
    parameter int         DATA_BYTES = 256,
    parameter logic [7:0] MARK_BYTE  = 8'h58
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       byte_valid_i,
    input  logic [7:0] byte_i,
    output logic       done_o,
    output logic       pass_o
);

    localparam int TOTAL_BYTES = DATA_BYTES + CHECK_COUNT;
    localparam int CW          = $clog2(TOTAL_BYTES + 1);

    sce_state_t    state_q, state_d;
    logic [CW-1:0] cnt;
    logic [CW-1:0] chk_pos;
    logic          accept;
    logic          last_seed, last_data, last_check;
    logic [7:0]    c_val, d_val, e_val;
    logic          ok_so_far, byte_match;

    assign accept     = byte_valid_i && !start_i && (state_q != ST_IDLE);
    assign last_seed  = (cnt == CW'(SEED_COUNT - 1));
    assign last_data  = (cnt == CW'(DATA_BYTES - 1));
    assign last_check = (cnt == CW'(TOTAL_BYTES - 1));
    assign chk_pos    = cnt - CW'(DATA_BYTES);

    sce_byte_counter #(.CW(CW)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_i),
        .step_i  (accept),
        .cnt_o   (cnt)
    );

    sce_fold_regs fold_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .seed_en_i  (accept && state_q == ST_SEED),
        .seed_sel_i (cnt[1:0]),
        .fold_en_i  (accept && state_q == ST_FOLD),
        .byte_i     (byte_i),
        .c_o        (c_val),
        .d_o        (d_val),
        .e_o        (e_val)
    );

    sce_verdict #(.MARK(MARK_BYTE)) verdict_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_i),
        .cmp_en_i  (accept && state_q == ST_CHECK),
        .cmp_sel_i (chk_pos[1:0]),
        .byte_i    (byte_i),
        .c_i       (c_val),
        .d_i       (d_val),
        .e_i       (e_val),
        .ok_o      (ok_so_far),
        .match_o   (byte_match)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: T_START, T_SEEDED, T_FOLDED, T_VERDICT
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_SEED;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_SEED:  if (accept && last_seed)  state_d = ST_FOLD;
                ST_FOLD:  if (accept && last_data)  state_d = ST_CHECK;
                ST_CHECK: if (accept && last_check) state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            pass_o <= 1'b0;
        end else if (start_i) begin
            done_o <= 1'b0;
            pass_o <= 1'b0;
        end else if (accept && state_q == ST_CHECK && last_check) begin
            done_o <= 1'b1;
            pass_o <= ok_so_far && byte_match;
        end else begin
            done_o <= 1'b0;
        end
    end

    // R5: single-cycle completion pulse, sourced from the check phase
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(state_q) == ST_CHECK && state_q == ST_IDLE));
    assert_pass_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (done_o || $stable(pass_o)));

    // R1: a start always re-enters the seed phase
    assert_start_seed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state_q == ST_SEED && !done_o));

    // R7: idle stays idle without a start
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_i) |=> (state_q == ST_IDLE && !done_o));

endmodule

// File: tb/sector_check_engine_tb_top.sv
module sector_check_engine_tb_top;

    localparam int NDATA = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       byte_valid_i = 1'b0;
    logic [7:0] byte_i = 8'h00;
    logic       done_o;
    logic       pass_o;

    int checks = 0;
    int fails  = 0;
    logic [7:0] sec [NDATA];

    always #2 clk = ~clk;   // 250 MHz

    sector_check_engine dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .byte_valid_i (byte_valid_i),
        .byte_i       (byte_i),
        .done_o       (done_o),
        .pass_o       (pass_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference model of the checksum from the requirements (C,D,E packed)
    function automatic logic [23:0] ref_sum();
        logic [7:0] c, d, e, nc, nd, ne;
        c = sec[0]; d = sec[1]; e = sec[2];
        for (int i = 3; i < NDATA; i++) begin
            nc = d ^ {7'd0, c[7]};
            nd = {c[6:0], 1'b0} ^ e;
            ne = c ^ sec[i];
            c = nc; d = nd; e = ne;
        end
        return {c, d, e};
    endfunction

    task automatic fill_random();
        for (int i = 0; i < NDATA; i++) sec[i] = 8'($urandom);
    endtask

    task automatic put_byte(input logic [7:0] b, input int gap_pct);
        while (($urandom % 100) < gap_pct) begin
            byte_valid_i = 1'b0;
            byte_i = 8'($urandom);
            @(negedge clk);
        end
        byte_valid_i = 1'b1;
        byte_i = b;
        @(negedge clk);
    endtask

    // Sends one sector; corrupt_idx 0..3 flips that check byte by mask, 4 = none
    task automatic run_sector(input int gap_pct, input int corrupt_idx, input logic [7:0] mask,
                              input bit start_with_byte, input string req);
        logic [23:0] s;
        logic [7:0]  tail [4];
        bit early;
        bit expect_pass;
        s = ref_sum();
        tail[0] = s[23:16]; tail[1] = s[15:8]; tail[2] = s[7:0]; tail[3] = 8'h58;
        if (corrupt_idx < 4) tail[corrupt_idx] = tail[corrupt_idx] ^ mask;
        expect_pass = (corrupt_idx >= 4) || (mask == 8'h00);
        early = 1'b0;
        start_i = 1'b1;
        byte_valid_i = start_with_byte;   // R1: same-cycle byte must be dropped
        byte_i = 8'($urandom);
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < NDATA; i++) begin
            put_byte(sec[i], gap_pct);
            if (done_o) early = 1'b1;
        end
        for (int k = 0; k < 3; k++) begin
            put_byte(tail[k], gap_pct);
            if (done_o) early = 1'b1;
        end
        put_byte(tail[3], gap_pct);
        byte_valid_i = 1'b0;
        chk(!early, {req, " R5 no early done"}, 32'(early), 0);
        chk(done_o === 1'b1, {req, " R5 done due"}, 32'(done_o), 1);
        chk(pass_o === expect_pass, {req, " R4 verdict"}, 32'(pass_o), 32'(expect_pass));
        @(negedge clk);
        chk(done_o === 1'b0, {req, " R5 done one cycle"}, 32'(done_o), 0);
        chk(pass_o === expect_pass, {req, " R5 pass held"}, 32'(pass_o), 32'(expect_pass));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        bit seen;
        void'($urandom(32'h5EC7_0A58));
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(done_o === 1'b0 && pass_o === 1'b0, "R8 reset outputs", {30'd0, done_o, pass_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: bytes while idle are ignored
        seen = 1'b0;
        for (int i = 0; i < 300; i++) begin
            byte_valid_i = 1'b1;
            byte_i = 8'($urandom);
            @(negedge clk);
            if (done_o) seen = 1'b1;
        end
        byte_valid_i = 1'b0;
        chk(!seen, "R7 idle bytes give no done", 32'(seen), 0);

        // R2 R3 R4: directed patterns, no gaps
        for (int i = 0; i < NDATA; i++) sec[i] = 8'h00;
        run_sector(0, 4, 8'h00, 1'b0, "R3 all-zero");
        for (int i = 0; i < NDATA; i++) sec[i] = 8'hFF;
        run_sector(0, 4, 8'h00, 1'b0, "R3 all-ones");
        for (int i = 0; i < NDATA; i++) sec[i] = 8'(i);
        run_sector(0, 4, 8'h00, 1'b0, "R2 ramp");

        // R6: random sectors with random stall cycles
        for (int n = 0; n < 6; n++) begin
            fill_random();
            run_sector(n * 10, 4, 8'h00, 1'b0, "R6 random");
        end

        // R4: each check byte corrupted in turn
        for (int k = 0; k < 4; k++) begin
            fill_random();
            run_sector(20, k, 8'(1 + ($urandom % 255)), 1'b0, "R4 corrupt");
        end
        // R4: single-bit flip in the marker
        fill_random();
        run_sector(0, 3, 8'h01, 1'b0, "R4 marker bit");

        // R1: start carries a stray byte that must be dropped
        fill_random();
        run_sector(5, 4, 8'h00, 1'b1, "R1 start with byte");

        // R9: abandon a partial sector, then a full one
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 120; i++) put_byte(8'($urandom), 0);
        byte_valid_i = 1'b0;
        fill_random();
        run_sector(10, 4, 8'h00, 1'b0, "R9 restart");

        // R1: start clears a held verdict
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(pass_o === 1'b0 && done_o === 1'b0, "R1 start clears verdict", {30'd0, done_o, pass_o}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule